// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two 18-bit ports, A and B, with one independent storage stage per direction (A to B and B to A). Each stage has three modes. In pass-through mode the opposite port shows the incoming data directly. In hold mode the stored word stays as it is. In capture mode a rising edge on that direction's strobe loads the incoming word. A direction follows its input while its latch-enable is high. When the latch-enable is low, the direction captures only on a strobe rising edge that is qualified by its active-low clock-enable. The path is non-inverting.

The block replaces internal three-state buffers with a per-bit drive-enable vector next to each data output. A parent level or the pad ring applies these enables. A single flag reports when both directions are enabled at the same time, which would make the two sides fight over a shared wire. All activity is sampled on one system clock. A strobe edge is found by comparing the strobe with its value at the previous system-clock edge.

Top module: `ubt_transceiver`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, bit for bit and without inversion.
- R2: While `ab_le` is 0 and no qualified strobe edge occurs, `b_out` keeps the stored word from cycle to cycle.
- R3: A qualified strobe edge loads the `a_in` value sampled at that clock edge into storage. The edge is qualified when, at a system-clock edge, `ab_le` is 0, `ab_cp` is 1 after being 0 at the previous system-clock edge, and `ab_ce_n` is 0. `b_out` shows the loaded word from the following cycle onward.
- R4: A strobe rising edge while `ab_ce_n` is 1 leaves the stored word, and therefore `b_out`, unchanged.
- R5: When `ab_le` falls from 1 to 0, storage keeps the last `a_in` sampled while `ab_le` was 1. That word stays until the next qualified edge.
- R6: `b_oe` is all ones when `ab_oe_n` is 0 and all zeros when `ab_oe_n` is 1. `a_oe` follows `ba_oe_n` in the same way. The data outputs are not affected by the enables.
- R7: The B-to-A path (`b_in`, `ba_le`, `ba_cp`, `ba_ce_n`, `ba_oe_n`, `a_out`, `a_oe`) behaves as described in R1 to R6 and is independent of the A-to-B controls.
- R8: A synchronous reset (`rst` = 1 at a clock edge) clears both stored words to zero and clears the strobe history. The output enables are not overridden by reset.
- R9: `bus_clash` is 1 exactly when `ab_oe_n` and `ba_oe_n` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Data arriving on port A |
| b_in | input | 18 | Data arriving on port B |
| ab_le | input | 1 | A-to-B pass-through select, active high |
| ab_cp | input | 1 | A-to-B capture strobe |
| ab_ce_n | input | 1 | A-to-B strobe qualifier, active low |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ba_le | input | 1 | B-to-A pass-through select, active high |
| ba_cp | input | 1 | B-to-A capture strobe |
| ba_ce_n | input | 1 | B-to-A strobe qualifier, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| b_out | output | 18 | Data presented on port B |
| b_oe | output | 18 | Per-bit drive enable for port B |
| a_out | output | 18 | Data presented on port A |
| a_oe | output | 18 | Per-bit drive enable for port A |
| bus_clash | output | 1 | Both directions enabled at once |

## Verification
The properties assume that every control and data input is stable around the rising edge of `clk`. They also assume that a strobe is a level sampled by `clk`, so a strobe pulse shorter than one system-clock period is not counted as an edge. The hold and capture checks are disabled in the cycle right after reset. In that cycle the strobe history has just been cleared and does not match the strobe's previous level. The stimulus changes every input on the falling edge of `clk` only, holds the strobes low through reset, and toggles the strobes at the system-clock rate so that every edge it produces is visible.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // Control bundle for one direction of the transceiver.
    typedef struct packed {
        logic le;    // pass-through select
        logic cp;    // capture strobe level
        logic ce_n;  // strobe qualifier, active low
        logic oe_n;  // drive enable, active low
    } dir_ctl_t;

    // Action taken by a storage stage at a system-clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_FOLLOW  = 2'd1,
        ACT_CAPTURE = 2'd2
    } store_act_t;

    // Pass-through has priority; otherwise only a qualified edge loads.
    function automatic store_act_t pick_act(input logic le,
                                            input logic rise,
                                            input logic ce_n);
        if (le)
            return ACT_FOLLOW;
        else if (rise && !ce_n)
            return ACT_CAPTURE;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= 1'b0;
        else
            lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ubt_store.sv
module ubt_store
    import ubt_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          le,
    input  logic          cp,
    input  logic          ce_n,
    output logic [DW-1:0] held
);
    logic       cp_rise;
    store_act_t act;

    ubt_edge_det edge_i (
        .clk  (clk),
        .rst  (rst),
        .lvl  (cp),
        .rise (cp_rise)
    );

    assign act = pick_act(le, cp_rise, ce_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            case (act)
                ACT_FOLLOW,
                ACT_CAPTURE: held <= din;
                default:     held <= held;
            endcase
        end
    end
endmodule

// File: rtl/ubt_drive.sv
module ubt_drive #(
    parameter int DW = 18
) (
    input  logic          oe_n,
    output logic [DW-1:0] en_vec
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign en_vec[i] = ~oe_n;
    end
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
    import ubt_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  dir_ctl_t      ctl,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] drv_en
);
    logic [DW-1:0] held;

    ubt_store #(.DW(DW)) store_i (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .le   (ctl.le),
        .cp   (ctl.cp),
        .ce_n (ctl.ce_n),
        .held (held)
    );

    ubt_drive #(.DW(DW)) drive_i (
        .oe_n   (ctl.oe_n),
        .en_vec (drv_en)
    );

    // Pass-through bypasses storage within the same cycle.
    assign dout = ctl.le ? din : held;
endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
    import ubt_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic          ab_le,
    input  logic          ab_cp,
    input  logic          ab_ce_n,
    input  logic          ab_oe_n,
    input  logic          ba_le,
    input  logic          ba_cp,
    input  logic          ba_ce_n,
    input  logic          ba_oe_n,
    output logic [DW-1:0] b_out,
    output logic [DW-1:0] b_oe,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] a_oe,
    output logic          bus_clash
);
    localparam int NLANE = 2;  // lane 0: A to B, lane 1: B to A

    logic [DW-1:0] lane_din [NLANE];
    logic [DW-1:0] lane_dout[NLANE];
    logic [DW-1:0] lane_en  [NLANE];
    dir_ctl_t      lane_ctl [NLANE];

    assign lane_din[0] = a_in;
    assign lane_din[1] = b_in;
    assign lane_ctl[0] = '{le: ab_le, cp: ab_cp, ce_n: ab_ce_n, oe_n: ab_oe_n};
    assign lane_ctl[1] = '{le: ba_le, cp: ba_cp, ce_n: ba_ce_n, oe_n: ba_oe_n};

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        ubt_lane #(.DW(DW)) lane_i (
            .clk    (clk),
            .rst    (rst),
            .din    (lane_din[l]),
            .ctl    (lane_ctl[l]),
            .dout   (lane_dout[l]),
            .drv_en (lane_en[l])
        );
    end

    assign b_out = lane_dout[0];
    assign b_oe  = lane_en[0];
    assign a_out = lane_dout[1];
    assign a_oe  = lane_en[1];

    assign bus_clash = ~ab_oe_n & ~ba_oe_n;
endmodule

// File: rtl/ubt_checker.sv
module ubt_checker #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] a_in,
    input logic [DW-1:0] b_in,
    input logic          ab_le,
    input logic          ab_cp,
    input logic          ab_ce_n,
    input logic          ab_oe_n,
    input logic          ba_le,
    input logic          ba_cp,
    input logic          ba_ce_n,
    input logic          ba_oe_n,
    input logic [DW-1:0] b_out,
    input logic [DW-1:0] b_oe,
    input logic [DW-1:0] a_out,
    input logic [DW-1:0] a_oe,
    input logic          bus_clash
);
    p_follow_r1: assert property (@(posedge clk) disable iff (rst)
        ab_le |-> (b_out == a_in));

    p_follow_r7: assert property (@(posedge clk) disable iff (rst)
        ba_le |-> (a_out == b_in));

    p_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ab_le && !(ab_cp && !$past(ab_cp) && !ab_ce_n))
        |=> (ab_le || $stable(b_out)));

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ab_le && ab_cp && !$past(ab_cp) && !ab_ce_n)
        |=> (ab_le || b_out == $past(a_in)));

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ba_le && ba_cp && !$past(ba_cp) && !ba_ce_n)
        |=> (ba_le || a_out == $past(b_in)));

    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ab_le && ab_cp && !$past(ab_cp) && ab_ce_n)
        |=> (ab_le || $stable(b_out)));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !ab_oe_n && !ab_oe_n) ##1 (!ab_le && !ab_cp)
        |-> (b_out == $past(a_in)));

    p_drive_r6: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |-> (b_oe == '0));

    p_drive_on_r6: assert property (@(posedge clk) disable iff (rst)
        !ba_oe_n |-> (a_oe == '1));

    p_clash_r9: assert property (@(posedge clk) disable iff (rst)
        bus_clash |-> ((&a_oe) && (&b_oe)));

    p_clear_r8: assert property (@(posedge clk)
        ($past(rst) && !rst && !ab_le && !ba_le) |-> (b_out == '0 && a_out == '0));
endmodule

bind ubt_transceiver ubt_checker #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .a_in      (a_in),
    .b_in      (b_in),
    .ab_le     (ab_le),
    .ab_cp     (ab_cp),
    .ab_ce_n   (ab_ce_n),
    .ab_oe_n   (ab_oe_n),
    .ba_le     (ba_le),
    .ba_cp     (ba_cp),
    .ba_ce_n   (ba_ce_n),
    .ba_oe_n   (ba_oe_n),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .bus_clash (bus_clash)
);

// File: tb/ubt_transceiver_tb.sv
module ubt_transceiver_tb_top;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] a_in, b_in;
    logic          ab_le, ab_cp, ab_ce_n, ab_oe_n;
    logic          ba_le, ba_cp, ba_ce_n, ba_oe_n;
    logic [DW-1:0] b_out, b_oe, a_out, a_oe;
    logic          bus_clash;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state for both directions
    logic [DW-1:0] m_ab, m_ba;
    logic          m_ab_cpq, m_ba_cpq;

    always #2 clk = ~clk;

    ubt_transceiver #(.DW(DW)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
        .bus_clash(bus_clash)
    );

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic le, input logic cp,
                                     input logic cpq, input logic ce_n,
                                     input string base_le);
        if (le)               return base_le;
        if (cp && !cpq && ce_n) return "R4";
        return "R2/R3";
    endfunction

    // Compare all outputs against the reference, outputs being
    // combinational from inputs plus the state after the last edge.
    task automatic compare_all();
        logic [DW-1:0] eb, ea;
        eb = ab_le ? a_in : m_ab;
        ea = ba_le ? b_in : m_ba;
        chk(tag_of(ab_le, ab_cp, m_ab_cpq, ab_ce_n, "R1"), b_out, eb);
        chk(ba_le ? "R7 follow" : "R7 store", a_out, ea);
        chk("R6 b_oe", b_oe, {DW{~ab_oe_n}});
        chk("R6 a_oe", a_oe, {DW{~ba_oe_n}});
        chk("R9", {{(DW-1){1'b0}}, bus_clash}, {{(DW-1){1'b0}}, ~ab_oe_n & ~ba_oe_n});
    endtask

    // Apply inputs after the falling edge, check, then advance the model
    // over the next rising edge.
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        if (rst) begin
            m_ab = '0; m_ba = '0; m_ab_cpq = 1'b0; m_ba_cpq = 1'b0;
        end else begin
            if (ab_le || (ab_cp && !m_ab_cpq && !ab_ce_n)) m_ab = a_in;
            if (ba_le || (ba_cp && !m_ba_cpq && !ba_ce_n)) m_ba = b_in;
            m_ab_cpq = ab_cp;
            m_ba_cpq = ba_cp;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] frozen;
        m_ab = 'x; m_ba = 'x; m_ab_cpq = 1'b0; m_ba_cpq = 1'b0;
        rst = 1'b1;
        a_in = 18'h2AAAA; b_in = 18'h15555;
        ab_le = 0; ab_cp = 0; ab_ce_n = 1; ab_oe_n = 1;
        ba_le = 0; ba_cp = 0; ba_ce_n = 1; ba_oe_n = 1;
        @(negedge clk);
        @(posedge clk);
        m_ab = '0; m_ba = '0;
        @(negedge clk);
        rst = 1'b1;
        step();
        rst = 1'b0;
        // R8: stored words are zero after reset while holding
        #1;
        chk("R8 b_out", b_out, '0);
        chk("R8 a_out", a_out, '0);
        @(negedge clk);

        // R5: freeze on leaving pass-through
        ab_le = 1; a_in = 18'h3C0F1; step();
        frozen = 18'h3C0F1;
        ab_le = 0; a_in = 18'h00FFF; step();
        a_in = 18'h12345; step();
        #1;
        chk("R5 freeze", b_out, frozen);
        @(negedge clk);

        // R3/R4: qualified vs. blocked strobe
        a_in = 18'h0BEEF; ab_ce_n = 1; ab_cp = 1; step();
        #1; chk("R4 gated edge", b_out, frozen); @(negedge clk);
        ab_cp = 0; step();
        ab_ce_n = 0; ab_cp = 1; step();
        #1; chk("R3 load", b_out, 18'h0BEEF); @(negedge clk);
        ab_cp = 0; ab_ce_n = 1;

        // R6/R9: all output-enable combinations
        for (int k = 0; k < 4; k++) begin
            ab_oe_n = k[0]; ba_oe_n = k[1]; step();
        end

        // Near-exhaustive sweep of control combinations with random data
        for (int n = 0; n < 4096; n++) begin
            logic [7:0] c;
            c = n[7:0];
            a_in = DW'($urandom());
            b_in = DW'($urandom());
            ab_le = c[0]; ab_cp = c[1]; ab_ce_n = c[2]; ab_oe_n = c[3];
            ba_le = c[4]; ba_cp = c[5]; ba_ce_n = c[6]; ba_oe_n = c[7];
            if (n[11:8] == 4'd5) begin
                ab_le = 0; ba_le = 0;       // long storage stretches
            end
            rst = (n == 2000);              // R8 mid-run reset
            if (rst) begin ab_cp = 0; ba_cp = 0; end
            step();
            rst = 1'b0;
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule